// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the command front end of a small SPI serial byte memory. It runs on a system clock, oversamples the SPI pins (mode 0: data taken on the rising SCK edge and changed on the falling edge), and decodes an 8-bit opcode after chip select falls. The commands are: set and clear the write-enable latch, read and write the status register, read data, and page write. SO is driven only when the enable output is high. At all other times the pad is high impedance.

A pause input suspends a transaction without deselecting the device. While the transaction is paused, SCK and SI are ignored and SO is released. Page-write data is collected in a page buffer. It is programmed only when chip select rises on a byte boundary. After that, a timed internal write cycle starts, and during that cycle the block accepts only status reads.

Top module: `spi_mem_slave`

## Requirements
- R1: A pause starts only while SCK is low and hold_ni is low, and it ends only while SCK is low and hold_ni is high. Driving hold_ni low while SCK is high does not pause the transaction until SCK returns low.
- R2: While paused, so_oe_o is low and SCK and SI edges are ignored. After resume, the transaction continues from the bit where it stopped.
- R3: After reset the status register reads 0x00 (write-enable latch clear, not busy), the memory reads 0x00, and so_oe_o is low whenever cs_ni_i is high.
- R4: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x04 clears it.
- R5: Opcode 0x05 returns the status byte MSB first, repeated for every further byte clocked. The layout is {user bits [7:2], latch bit 1, busy bit 0}. The status can be read during an internal write cycle.
- R6: Opcode 0x03 is followed by a 16-bit address, MSB first, of which the low log2(MEM_BYTES) bits are used. Each data bit appears on SO after a falling SCK edge. The address auto-increments per byte and wraps at the end of the array.
- R7: Opcode 0x02 is followed by a 16-bit address and data bytes. It is accepted only with the latch set. The address wraps within a PAGE_BYTES-aligned page, so a later byte at the same offset replaces an earlier one.
- R8: A page write is programmed only if chip select rises on a byte boundary after at least one data byte. Otherwise the memory is unchanged and the latch stays set.
- R9: A successful page or status write clears the latch and holds status bit 0 high for WR_CYCLES system clocks.
- R10: During the internal write cycle every opcode except 0x05 is ignored: no output is driven and the latch does not change.
- R11: An unknown opcode is ignored. so_oe_o stays low for the rest of that selection and the state does not change.
- R12: Opcode 0x01 with the latch set and exactly one data byte writes status bits [7:2] when chip select rises. Any other byte count leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock, idles low |
| cs_ni_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for SO; low means high impedance |

## Verification
The pause logic and the output shifter can act on the same system clock. This happens when hold_ni has been driven low while SCK is high and SCK then falls: that falling edge must still shift out the next data bit, and the pause takes effect on the same clock. The bench provokes this in the middle of a read data byte. It checks that the output stays enabled while SCK is high and is released after the fall. It also clocks extra SCK pulses during the pause, then checks every byte of the read against the model. The bench also overlaps the end of a write cycle with an ignored read that it has already rejected, and checks that the output stays released through the whole selection.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_SRD,
    ST_SWR,
    ST_SKIP
  } phase_e;
endpackage

// File: rtl/spi_mem_hold.sv
module spi_mem_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni_i,
  input  logic sck_i,
  input  logic hold_ni,
  output logic paused_o
);
  // pause state follows hold only while sck is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      paused_o <= 1'b0;
    else if (cs_ni_i) paused_o <= 1'b0;
    else if (!sck_i)  paused_o <= ~hold_ni;
  end
endmodule

// File: rtl/spi_mem_timer.sv
module spi_mem_timer #(
  parameter int WR_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int TW = $clog2(WR_CYCLES + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= TW'(WR_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/spi_mem_pagebuf.sv
module spi_mem_pagebuf #(
  parameter int PAGE_BYTES = 16,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       we_i,
  input  logic [PW-1:0]              off_i,
  input  logic [7:0]                 wdata_i,
  output logic [PAGE_BYTES-1:0][7:0] data_o,
  output logic [PAGE_BYTES-1:0]      mask_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g] <= '0;
        mask_o[g] <= 1'b0;
      end else if (clr_i) begin
        mask_o[g] <= 1'b0;
      end else if (we_i && off_i == PW'(g)) begin
        data_o[g] <= wdata_i;
        mask_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [AW-PW-1:0]           base_i,
  input  logic [PAGE_BYTES-1:0][7:0] data_i,
  input  logic [PAGE_BYTES-1:0]      mask_i,
  input  logic [AW-1:0]              raddr_i,
  output logic [7:0]                 rdata_o
);
  logic [MEM_BYTES-1:0][7:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (commit_i) begin
      for (int p = 0; p < PAGE_BYTES; p++) begin
        if (mask_i[p]) mem_q[{base_i, PW'(p)}] <= data_i[p];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic so_o,
  output logic so_oe_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = AW - PW;

  phase_e        phase;
  logic          sck_q, cs_q;
  logic          paused, busy, wel;
  logic [5:0]    usr, sr_pend;
  logic [7:0]    sh_in, sh_out, in_byte, status, out_byte, mem_rdata;
  logic [2:0]    bit_cnt;
  logic [3:0]    addr_cnt;
  logic [1:0]    nb;
  logic [AW-1:0] addr;
  logic          rd_cmd, started, so_q;
  logic          sel, sck_rise, sck_fall, cs_rise, byte_done, rd_phase;
  logic          wr_commit, sr_commit, pb_clr, pb_we;
  logic [PAGE_BYTES-1:0][7:0] pb_data;
  logic [PAGE_BYTES-1:0]      pb_mask;
  phase_e        dec_phase;
  logic          dec_wel_set, dec_wel_clr, dec_rd;

  spi_mem_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni_i  (cs_ni_i),
    .sck_i    (sck_i),
    .hold_ni  (hold_ni),
    .paused_o (paused)
  );

  spi_mem_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_commit | sr_commit),
    .busy_o  (busy)
  );

  spi_mem_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pagebuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (pb_clr),
    .we_i    (pb_we),
    .off_i   (addr[PW-1:0]),
    .wdata_i (in_byte),
    .data_o  (pb_data),
    .mask_o  (pb_mask)
  );

  spi_mem_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (wr_commit),
    .base_i   (addr[AW-1:PW]),
    .data_i   (pb_data),
    .mask_i   (pb_mask),
    .raddr_i  (addr),
    .rdata_o  (mem_rdata)
  );

  assign sel       = ~cs_ni_i;
  assign sck_rise  = sel & ~paused & sck_i & ~sck_q;
  assign sck_fall  = sel & ~paused & ~sck_i & sck_q;
  assign cs_rise   = cs_ni_i & ~cs_q;
  assign in_byte   = {sh_in[6:0], si_i};
  assign byte_done = sck_rise & (bit_cnt == 3'd7);
  assign rd_phase  = (phase == ST_RDATA) | (phase == ST_SRD);
  assign wr_commit = cs_rise & (phase == ST_WDATA) & (bit_cnt == 3'd0) & (nb != 2'd0);
  assign sr_commit = cs_rise & (phase == ST_SWR) & (bit_cnt == 3'd0) & (nb == 2'd1);
  assign pb_clr    = sck_rise & (phase == ST_ADDR) & (addr_cnt == 4'd15) & ~rd_cmd;
  assign pb_we     = byte_done & (phase == ST_WDATA);
  assign status    = {usr, wel, busy};
  assign out_byte  = (phase == ST_SRD) ? status : mem_rdata;
  assign so_oe_o   = sel & ~paused & started & rd_phase;
  assign so_o      = so_q;

  // opcode decode; during a write cycle only status read survives
  always_comb begin
    dec_phase   = ST_SKIP;
    dec_wel_set = 1'b0;
    dec_wel_clr = 1'b0;
    dec_rd      = 1'b0;
    if (busy) begin
      if (in_byte == OP_RDSR) dec_phase = ST_SRD;
    end else begin
      case (in_byte)
        OP_WREN:  dec_wel_set = 1'b1;
        OP_WRDI:  dec_wel_clr = 1'b1;
        OP_RDSR:  dec_phase   = ST_SRD;
        OP_WRSR:  if (wel) dec_phase = ST_SWR;
        OP_READ: begin
          dec_phase = ST_ADDR;
          dec_rd    = 1'b1;
        end
        OP_WRITE: if (wel) dec_phase = ST_ADDR;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase    <= ST_IDLE;
      sh_in    <= '0;
      sh_out   <= '0;
      bit_cnt  <= '0;
      addr_cnt <= '0;
      nb       <= '0;
      addr     <= '0;
      rd_cmd   <= 1'b0;
      started  <= 1'b0;
      so_q     <= 1'b0;
      sr_pend  <= '0;
    end else if (cs_ni_i) begin
      phase    <= ST_IDLE;
      bit_cnt  <= '0;
      addr_cnt <= '0;
      nb       <= '0;
      started  <= 1'b0;
    end else if (phase == ST_IDLE) begin
      phase <= ST_OPC;
    end else begin
      if (sck_rise) begin
        sh_in   <= in_byte;
        bit_cnt <= bit_cnt + 1'b1;
        case (phase)
          ST_OPC: if (byte_done) begin
            phase  <= dec_phase;
            rd_cmd <= dec_rd;
          end
          ST_ADDR: begin
            addr     <= {addr[AW-2:0], si_i};
            addr_cnt <= addr_cnt + 1'b1;
            if (addr_cnt == 4'd15) phase <= rd_cmd ? ST_RDATA : ST_WDATA;
          end
          ST_WDATA: if (byte_done) begin
            addr <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
            if (nb != 2'd2) nb <= nb + 1'b1;
          end
          ST_SWR: if (byte_done) begin
            sr_pend <= in_byte[7:2];
            if (nb != 2'd2) nb <= nb + 1'b1;
          end
          ST_RDATA: if (byte_done) addr <= addr + 1'b1;
          default: ;
        endcase
      end
      if (sck_fall && rd_phase) begin
        started <= 1'b1;
        if (bit_cnt == 3'd0) begin
          so_q   <= out_byte[7];
          sh_out <= {out_byte[6:0], 1'b0};
        end else begin
          so_q   <= sh_out[7];
          sh_out <= {sh_out[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel <= 1'b0;
      usr <= '0;
    end else begin
      if (wr_commit || sr_commit)                           wel <= 1'b0;
      else if (byte_done && phase == ST_OPC && dec_wel_set) wel <= 1'b1;
      else if (byte_done && phase == ST_OPC && dec_wel_clr) wel <= 1'b0;
      if (sr_commit) usr <= sr_pend;
    end
  end

  logic unused_bw;
  assign unused_bw = ^BW;
endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_i,
  input logic cs_ni_i,
  input logic so_oe_o,
  input logic paused,
  input logic busy,
  input logic wel
);
  AST_PAUSE_ENTRY_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused) |-> !$past(sck_i)); // R1
  AST_PAUSE_EXIT_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(paused) && !$past(cs_ni_i)) |-> !$past(sck_i)); // R1
  AST_NO_DRIVE_PAUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused |-> !so_oe_o); // R2
  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni_i |-> !so_oe_o); // R3
  AST_COMMIT_ON_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cs_ni_i)); // R8
  AST_WEL_CLEARED_AT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !wel); // R9
  AST_NO_WEL_SET_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> !$past(busy)); // R10
endmodule

bind spi_mem_slave spi_mem_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sck_i   (sck_i),
  .cs_ni_i (cs_ni_i),
  .so_oe_o (so_oe_o),
  .paused  (paused),
  .busy    (busy),
  .wel     (wel)
);

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;
  localparam int MEMB = 256;
  localparam int PAGE = 16;
  localparam int WRC  = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] model [MEMB];
  logic [7:0] wbuf [32];
  logic       wel_m;
  logic [5:0] usr_m;

  always #10 clk = ~clk;

  spi_mem_slave #(.MEM_BYTES(MEMB), .PAGE_BYTES(PAGE), .WR_CYCLES(WRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni_i(cs_n), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe)
  );

  function automatic logic [7:0] exp_status(input logic bz);
    return {usr_m, wel_m, bz};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode 1: pause before the rise with extra clocks; mode 2: hold low while sck high
  task automatic spi_bit(input logic b, input int mode, output logic r, output logic oe);
    si = b;
    tick(4);
    if (mode == 1) begin
      hold_n = 1'b0;
      tick(3);
      check("R2 pause releases SO", int'(so_oe), 0);
      for (int k = 0; k < 2; k++) begin
        sck = 1'b1; si = ~si; tick(3);
        sck = 1'b0; tick(3);
      end
      check("R2 SO stays released while clocks run", int'(so_oe), 0);
      si = b;
      hold_n = 1'b1;
      tick(3);
    end
    r  = so;
    oe = so_oe;
    sck = 1'b1;
    tick(4);
    if (mode == 2) begin
      hold_n = 1'b0;
      tick(3);
      check("R1 hold low with sck high does not pause", int'(so_oe), 1);
      sck = 1'b0;
      tick(3);
      check("R2 pause takes effect once sck low", int'(so_oe), 0);
      sck = 1'b1; tick(3);
      sck = 1'b0; tick(3);
      hold_n = 1'b1;
      tick(3);
    end else begin
      sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, input int hb, input int mode,
                          output logic [7:0] rx, output logic oe_all, output logic oe_any);
    logic r, oe;
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      spi_bit(tx[7-i], (i == hb) ? mode : 0, r, oe);
      rx[7-i] = r;
      oe_all &= oe;
      oe_any |= oe;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    tick(2);
  endtask

  task automatic cs_end();
    tick(2);
    cs_n = 1'b1;
    tick(4);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] rx; logic a, b;
    cs_begin();
    spi_byte(op, -1, 0, rx, a, b);
    cs_end();
    if (op == 8'h06) wel_m = 1'b1;
    if (op == 8'h04) wel_m = 1'b0;
  endtask

  task automatic rdsr(input string req, input logic [7:0] exp);
    logic [7:0] rx, rx2; logic a, b;
    cs_begin();
    spi_byte(8'h05, -1, 0, rx, a, b);
    spi_byte(8'h00, -1, 0, rx, a, b);
    check({req, " status value"}, int'(rx), int'(exp));
    check({req, " status driven"}, int'(a), 1);
    spi_byte(8'h00, -1, 0, rx2, a, b);
    check("R5 status repeats", int'(rx2), int'(exp));
    cs_end();
  endtask

  task automatic do_write(input int a, input int n, input int hb, input int hbit);
    logic [7:0] rx; logic x, y;
    cs_begin();
    spi_byte(8'h02, -1, 0, rx, x, y);
    spi_byte(8'h00, -1, 0, rx, x, y);
    spi_byte(8'(a), -1, 0, rx, x, y);
    for (int i = 0; i < n; i++) spi_byte(wbuf[i], (i == hb) ? hbit : -1, 1, rx, x, y);
    cs_end();
    if (wel_m && n > 0) begin
      for (int i = 0; i < n; i++)
        model[(a & ~(PAGE-1)) | ((a + i) & (PAGE-1))] = wbuf[i];
      wel_m = 1'b0;
    end
  endtask

  task automatic do_read(input string req, input int a, input int n,
                         input int hb, input int hbit, input int mode);
    logic [7:0] rx; logic x, y, all;
    all = 1'b1;
    cs_begin();
    spi_byte(8'h03, -1, 0, rx, x, y);
    spi_byte(8'h00, -1, 0, rx, x, y);
    spi_byte(8'(a), -1, 0, rx, x, y);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, (i == hb) ? hbit : -1, mode, rx, x, y);
      all &= x;
      check({req, " read byte"}, int'(rx), int'(model[(a + i) & (MEMB-1)]));
    end
    check({req, " read driven"}, int'(all), 1);
    cs_end();
  endtask

  task automatic wait_write();
    tick(WRC + 40);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rx; logic x, y;
    void'($urandom(32'h5A17));
    for (int i = 0; i < MEMB; i++) model[i] = 8'h00;
    wel_m = 1'b0;
    usr_m = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R3 reset state
    check("R3 SO released idle", int'(so_oe), 0);
    rdsr("R3 reset", 8'h00);
    do_read("R3 memory clear", 16, 4, -1, -1, 0);

    // R7 write refused without latch
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(8'h20, 4, -1, -1);
    rdsr("R7 no latch", 8'h00);
    do_read("R7 write refused", 8'h20, 4, -1, -1, 0);

    // R4 latch set/clear
    cmd1(8'h06);
    rdsr("R4 latch set", 8'h02);
    cmd1(8'h04);
    rdsr("R4 latch cleared", 8'h00);

    // R9 write cycle, R5 status read while busy
    cmd1(8'h06);
    do_write(8'h20, 4, -1, -1);
    rdsr("R9 R5 busy during write", 8'h01);
    wait_write();
    rdsr("R9 latch cleared after write", 8'h00);
    do_read("R6 read back", 8'h20, 4, -1, -1, 0);

    // R7 page wrap
    cmd1(8'h06);
    for (int i = 0; i < 5; i++) wbuf[i] = 8'h50 + 8'(i);
    do_write(8'h3E, 5, -1, -1);
    wait_write();
    do_read("R7 page wrap", 8'h30, 16, -1, -1, 0);

    // R8 aborted writes
    cmd1(8'h06);
    cs_begin();
    spi_byte(8'h02, -1, 0, rx, x, y);
    spi_byte(8'h00, -1, 0, rx, x, y);
    spi_byte(8'h50, -1, 0, rx, x, y);
    spi_byte(8'hEE, -1, 0, rx, x, y);
    for (int i = 0; i < 3; i++) spi_bit(1'b1, 0, x, y);
    cs_end();
    rdsr("R8 partial byte keeps latch", 8'h02);
    do_read("R8 partial byte no change", 8'h50, 2, -1, -1, 0);
    do_write(8'h50, 0, -1, -1);
    rdsr("R8 no data byte keeps latch", 8'h02);
    cmd1(8'h04);

    // R10 read during write cycle ignored
    cmd1(8'h06);
    wbuf[0] = 8'h77;
    do_write(8'h60, 1, -1, -1);
    cs_begin();
    spi_byte(8'h03, -1, 0, rx, x, y);
    begin
      logic any;
      any = 1'b0;
      for (int i = 0; i < 4; i++) begin
        spi_byte(8'h00, -1, 0, rx, x, y);
        any |= y;
      end
      check("R10 read during write cycle not driven", int'(any), 0);
    end
    cs_end();
    wait_write();
    // R10 latch set during write cycle ignored
    cmd1(8'h06);
    wbuf[0] = 8'h78;
    do_write(8'h61, 1, -1, -1);
    cmd1(8'h06);
    wel_m = 1'b0;
    wait_write();
    rdsr("R10 latch set ignored while busy", 8'h00);

    // R11 unknown opcode
    cmd1(8'h06);
    cs_begin();
    begin
      logic any;
      any = 1'b0;
      spi_byte(8'hAB, -1, 0, rx, x, y);
      for (int i = 0; i < 3; i++) begin
        spi_byte(8'h04, -1, 0, rx, x, y);
        any |= y;
      end
      check("R11 unknown opcode not driven", int'(any), 0);
    end
    cs_end();
    rdsr("R11 unknown opcode no effect", 8'h02);
    cmd1(8'h04);

    // R12 status write
    cs_begin();
    spi_byte(8'h01, -1, 0, rx, x, y);
    spi_byte(8'hFC, -1, 0, rx, x, y);
    cs_end();
    rdsr("R12 status write without latch", 8'h00);
    cmd1(8'h06);
    cs_begin();
    spi_byte(8'h01, -1, 0, rx, x, y);
    spi_byte(8'hA4, -1, 0, rx, x, y);
    cs_end();
    usr_m = 6'h29;
    wel_m = 1'b0;
    rdsr("R12 status write busy", 8'hA5);
    wait_write();
    rdsr("R12 status written", 8'hA4);
    cmd1(8'h06);
    cs_begin();
    spi_byte(8'h01, -1, 0, rx, x, y);
    spi_byte(8'h10, -1, 0, rx, x, y);
    spi_byte(8'h10, -1, 0, rx, x, y);
    cs_end();
    rdsr("R12 two bytes aborted", 8'hA6);
    cmd1(8'h04);

    // R6 wrap at array end
    cmd1(8'h06);
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    do_write(8'hFE, 2, -1, -1);
    wait_write();
    do_read("R6 array wrap", 8'hFF, 3, -1, -1, 0);

    // R1 R2 pause during read and write
    do_read("R2 pause mid read", 8'h30, 3, 0, 3, 1);
    do_read("R1 hold while sck high", 8'h30, 3, 1, 5, 2);
    cmd1(8'h06);
    for (int i = 0; i < 3; i++) wbuf[i] = 8'h3C + 8'(i);
    do_write(8'h84, 3, 1, 4);
    wait_write();
    do_read("R2 SI ignored while paused", 8'h84, 3, -1, -1, 0);

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      int a, n;
      a = int'($urandom_range(0, MEMB-1));
      if ($urandom_range(0, 1) == 1) begin
        n = int'($urandom_range(1, 20));
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        cmd1(8'h06);
        do_write(a, n, -1, -1);
        wait_write();
      end else begin
        n = int'($urandom_range(1, 6));
        do_read("R6 R7 random", a, n, -1, -1, 0);
      end
    end
    rdsr("R9 final status", exp_status(1'b0));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule